// File: doc/BRIEF.md
# Preloadable Two-Mode Down-Counter/Timer

This block is a 16-bit down-counter that a processor controls over a small byte-wide register bus. In counter mode it behaves like a stopwatch or a one-shot alarm. A read at the start command address loads the count from a preload value and starts counting. A read at the stop command address halts it. When the count reaches zero, the block raises a ready flag and drives its output active. The count then wraps to all ones and keeps going.

In timer mode the count runs without pause and reloads itself from the preload value. The output toggles at every terminal count, so the output is a square wave whose half-period is the preload value in source ticks.

Counting is paced by single-cycle tick enables rather than by separate clocks. Counter mode chooses one of four tick sources. Timer mode chooses the main tick or the external tick, and can pass the chosen tick through a divide-by-16 prescaler. The output pin is driven active low. An interrupt request follows the ready flag when the interrupt is enabled.

Top module: `preload_counter_timer`

## Requirements
- R1: After reset the block is in counter mode and stopped. The count, preload and configuration read as zero, `ready` and `irq` are 0, and `ctOutN` is 1.
- R2: Register map on `regAddr`, where writes and reads use the same address:
  - 0: preload high byte.
  - 1: preload low byte.
  - 2: configuration. Bit 0 selects timer mode, bits 2:1 select the source, bit 3 enables divide-by-16 and bit 4 enables the interrupt.
  - 3: count high byte.
  - 4: count low byte.
  - 5: status, with `ready` in bit 0.
  - 6: start command, taken on a read.
  - 7: stop command, taken on a read.

  A write to addresses 0–2 reads back the value written.
- R3: In counter mode, a start read loads the count from the preload on the next edge. From then on, each tick of the selected source lowers the count by one.
- R4: In counter mode, source select picks the tick input: 0 for `tickMain`, 1 for `tickChanA`, 2 for `tickChanB`, 3 for `tickExt`. Ticks on the other inputs leave the count unchanged.
- R5: In counter mode, a tick that moves the count from 1 to 0 sets `ready` and makes `ctOutN` low. The next tick moves the count from 0 to 0xFFFF and counting goes on, with `ready` still set.
- R6: In counter mode, writing the preload while counting leaves the running count untouched. The new preload is used at the next start read.
- R7: In counter mode, a stop read halts counting and clears `ready`. It also returns `ctOutN` to 1. Ticks after that leave the count unchanged.
- R8: A configuration write that changes the mode loads the count from the preload and clears `ready` and the output.
- R9: In timer mode the count decrements on every prescaled tick with no start needed. At the tick that finds the count at 1, the count reloads from the preload, the output toggles and `ready` is set, so each output half-period lasts preload ticks.
- R10: In timer mode a start read reloads the count and clears the prescaler. A stop read only clears `ready`, and counting goes on.
- R11: In timer mode, source select 3 uses `tickExt` and any other value uses `tickMain`. With divide-by-16 set, only every sixteenth tick of that source counts.
- R12: `irq` is high exactly while `ready` is 1 and the interrupt enable bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 3 | Register address |
| regWr | input | 1 | Write strobe |
| regRd | input | 1 | Read strobe (drives command addresses) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the addressed register |
| tickMain | input | 1 | Main clock tick enable |
| tickChanA | input | 1 | Channel A transmit tick enable |
| tickChanB | input | 1 | Channel B transmit tick enable |
| tickExt | input | 1 | External pin tick enable |
| ctOutN | output | 1 | Counter/timer output, active low |
| ready | output | 1 | Terminal-count ready flag |
| irq | output | 1 | Interrupt request |

## Verification
Counting is tried with pulses on the selected tick input and on inputs that are not selected. This separates correct source decoding from a mux that merges the inputs.

Counter-mode runs reach the 1-to-0 step and then the 0-to-0xFFFF step. They also include a preload rewrite in the middle of a run, which shows whether the preload is applied early.

Timer-mode runs with a small preload check the toggle spacing over two half-periods. Timer-mode runs with divide-by-16 check that fifteen ticks do nothing and the sixteenth counts. The stop and start reads in timer mode show that the CPU cannot halt the timer, but can clear the ready flag and restart the count.

// File: rtl/pct_pkg.sv
package pct_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_PRE_HI = 3'd0;
  localparam logic [ADDR_W-1:0] A_PRE_LO = 3'd1;
  localparam logic [ADDR_W-1:0] A_CFG    = 3'd2;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd4;
  localparam logic [ADDR_W-1:0] A_STAT   = 3'd5;
  localparam logic [ADDR_W-1:0] A_START  = 3'd6;
  localparam logic [ADDR_W-1:0] A_STOP   = 3'd7;

  localparam int CFG_W = 5;

  typedef enum logic [1:0] {
    SRC_MAIN = 2'd0,
    SRC_CHA  = 2'd1,
    SRC_CHB  = 2'd2,
    SRC_EXT  = 2'd3
  } srcSel_e;

  // Control-to-datapath strobes
  typedef struct packed {
    logic wrPreHi;
    logic wrPreLo;
    logic loadCnt;
    logic decCnt;
    logic setRdy;
    logic clrRdy;
    logic setOut;
    logic clrOut;
    logic tglOut;
  } ctlStb_t;
endpackage

// File: rtl/pct_ctrl.sv
module pct_ctrl
  import pct_pkg::*;
#(
  parameter int PRE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [CFG_W-1:0]  cfgIn,
  input  logic [3:0]        ticks,
  input  logic              cntIsOne,
  output ctlStb_t           stb,
  output logic [CFG_W-1:0]  cfgQ,
  output logic              timerMode
);
  localparam logic [PRE_W-1:0] PRE_LAST = {PRE_W{1'b1}};

  logic             running;
  logic [PRE_W-1:0] preCnt;
  srcSel_e          srcSel;
  logic             div16;
  logic             startCmd, stopCmd, cfgWr, modeChg;
  logic             srcTick, tmrTick, tmrEn;

  assign timerMode = cfgQ[0];
  assign srcSel    = srcSel_e'(cfgQ[2:1]);
  assign div16     = cfgQ[3];

  assign startCmd = regRd && (regAddr == A_START);
  assign stopCmd  = regRd && (regAddr == A_STOP);
  assign cfgWr    = regWr && (regAddr == A_CFG);
  assign modeChg  = cfgWr && (cfgIn[0] != timerMode);

  always_comb begin
    unique case (srcSel)
      SRC_MAIN: srcTick = ticks[0];
      SRC_CHA:  srcTick = ticks[1];
      SRC_CHB:  srcTick = ticks[2];
      default:  srcTick = ticks[3];
    endcase
  end

  // Timer mode uses the external tick for select 3, the main tick otherwise
  assign tmrTick = (srcSel == SRC_EXT) ? ticks[3] : ticks[0];
  assign tmrEn   = tmrTick && (!div16 || (preCnt == PRE_LAST));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ    <= '0;
      running <= 1'b0;
      preCnt  <= '0;
    end else begin
      if (cfgWr) cfgQ <= cfgIn;
      if (modeChg) begin
        running <= 1'b0;
        preCnt  <= '0;
      end else if (!timerMode) begin
        if (stopCmd)       running <= 1'b0;
        else if (startCmd) running <= 1'b1;
      end else begin
        if (startCmd)                preCnt <= '0;
        else if (tmrTick && div16)   preCnt <= preCnt + 1'b1;
      end
    end
  end

  always_comb begin
    stb         = '0;
    stb.wrPreHi = regWr && (regAddr == A_PRE_HI);
    stb.wrPreLo = regWr && (regAddr == A_PRE_LO);
    if (modeChg) begin
      stb.loadCnt = 1'b1;
      stb.clrRdy  = 1'b1;
      stb.clrOut  = 1'b1;
    end else if (!timerMode) begin
      if (stopCmd) begin
        stb.clrRdy = 1'b1;
        stb.clrOut = 1'b1;
      end else if (startCmd) begin
        stb.loadCnt = 1'b1;
      end else if (running && srcTick) begin
        stb.decCnt = 1'b1;
        if (cntIsOne) begin
          stb.setRdy = 1'b1;
          stb.setOut = 1'b1;
        end
      end
    end else begin
      if (stopCmd) stb.clrRdy = 1'b1;
      if (startCmd) begin
        stb.loadCnt = 1'b1;
      end else if (tmrEn) begin
        if (cntIsOne) begin
          stb.loadCnt = 1'b1;
          stb.tglOut  = 1'b1;
          stb.setRdy  = 1'b1;
        end else begin
          stb.decCnt = 1'b1;
        end
      end
    end
  end

  // R7: a stopped counter-mode block never issues a decrement
  p_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!timerMode && !running) |-> !stb.decCnt);

  // R11: prescaled timer tick fires only when the prescaler wraps
  p_div16_r11: assert property (@(posedge clk) disable iff (!rstN)
    (timerMode && div16 && stb.decCnt) |-> (preCnt == PRE_LAST));
endmodule

// File: rtl/pct_datapath.sv
module pct_datapath
  import pct_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStb_t           stb,
  input  logic [BYTE_W-1:0] wrData,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  preload,
  output logic              cntIsOne,
  output logic              ready,
  output logic              ctOut
);
  logic [1:0] byteWr;
  assign byteWr = {stb.wrPreHi, stb.wrPreLo};

  for (genvar b = 0; b < 2; b++) begin : g_preByte
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          preload[b*BYTE_W +: BYTE_W] <= '0;
      else if (byteWr[b]) preload[b*BYTE_W +: BYTE_W] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cnt <= '0;
    else if (stb.loadCnt) cnt <= preload;
    else if (stb.decCnt)  cnt <= cnt - 1'b1;
  end

  assign cntIsOne = (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ready <= 1'b0;
      ctOut <= 1'b0;
    end else begin
      if (stb.setRdy)      ready <= 1'b1;
      else if (stb.clrRdy) ready <= 1'b0;
      if (stb.clrOut)      ctOut <= 1'b0;
      else if (stb.setOut) ctOut <= 1'b1;
      else if (stb.tglOut) ctOut <= ~ctOut;
    end
  end

  // R3: a load copies the preload into the count
  p_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadCnt |=> (cnt == $past(preload)));

  // R5: decrementing zero wraps to all ones
  p_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.decCnt && !stb.loadCnt && cnt == '0) |=> (cnt == {CNT_W{1'b1}}));

  // R5: a terminal event leaves ready set
  p_ready_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.setRdy |=> ready);
endmodule

// File: rtl/preload_counter_timer.sv
module preload_counter_timer
  import pct_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PRE_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  input  logic              tickMain,
  input  logic              tickChanA,
  input  logic              tickChanB,
  input  logic              tickExt,
  output logic              ctOutN,
  output logic              ready,
  output logic              irq
);
  localparam int CNT_W = 2 * BYTE_W;

  ctlStb_t          stb;
  logic [CFG_W-1:0] cfgQ;
  logic             timerMode;
  logic [CNT_W-1:0] cnt, preload;
  logic             cntIsOne, ctOut;

  pct_ctrl #(.PRE_W(PRE_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .regWr    (regWr),
    .regRd    (regRd),
    .cfgIn    (wrData[CFG_W-1:0]),
    .ticks    ({tickExt, tickChanB, tickChanA, tickMain}),
    .cntIsOne (cntIsOne),
    .stb      (stb),
    .cfgQ     (cfgQ),
    .timerMode(timerMode)
  );

  pct_datapath #(.BYTE_W(BYTE_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wrData  (wrData),
    .cnt     (cnt),
    .preload (preload),
    .cntIsOne(cntIsOne),
    .ready   (ready),
    .ctOut   (ctOut)
  );

  assign ctOutN = ~ctOut;
  assign irq    = ready & cfgQ[4];

  always_comb begin
    unique case (regAddr)
      A_PRE_HI: rdData = preload[CNT_W-1 -: BYTE_W];
      A_PRE_LO: rdData = preload[BYTE_W-1:0];
      A_CFG:    rdData = BYTE_W'(cfgQ);
      A_CNT_HI: rdData = cnt[CNT_W-1 -: BYTE_W];
      A_CNT_LO: rdData = cnt[BYTE_W-1:0];
      A_STAT:   rdData = BYTE_W'(ready);
      default:  rdData = '0;
    endcase
  end

  // R7: a counter-mode stop read clears ready and the output
  p_stop_r7: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regAddr == A_STOP && !timerMode) |=> (!ready && ctOutN));

  // R12: the request never appears without the ready flag
  p_irq_r12: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ready);
endmodule

// File: tb/preload_counter_timer_bench.sv
module preload_counter_timer_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] regAddr = '0;
  logic       regWr = 1'b0, regRd = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       tickMain = 0, tickChanA = 0, tickChanB = 0, tickExt = 0;
  logic       ctOutN, ready, irq;
  int         nChecks = 0, nFails = 0;
  bit         done = 0;

  always #2 clk = ~clk;

  preload_counter_timer u_preload_counter_timer (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .wrData(wrData), .rdData(rdData), .tickMain(tickMain), .tickChanA(tickChanA),
    .tickChanB(tickChanB), .tickExt(tickExt), .ctOutN(ctOutN), .ready(ready), .irq(irq)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [2:0] a, logic [7:0] d);
    @(negedge clk); regAddr = a; wrData = d; regWr = 1'b1;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic busRead(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); regAddr = a; regRd = 1'b1;
    #1 d = rdData;
    @(negedge clk); regRd = 1'b0;
  endtask

  task automatic readCount(output logic [15:0] c);
    logic [7:0] hi, lo;
    busRead(3'd3, hi);
    busRead(3'd4, lo);
    c = {hi, lo};
  endtask

  task automatic cmd(logic [2:0] a);
    logic [7:0] d;
    busRead(a, d);
  endtask

  // which: 0 main, 1 chanA, 2 chanB, 3 ext
  task automatic ticks(int which, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tickMain = (which == 0); tickChanA = (which == 1);
      tickChanB = (which == 2); tickExt = (which == 3);
      @(negedge clk);
      tickMain = 0; tickChanA = 0; tickChanB = 0; tickExt = 0;
    end
  endtask

  task automatic testReset();
    logic [15:0] c; logic [7:0] d;
    readCount(c);        check("R1 count", c, 16'h0000);
    busRead(3'd2, d);    check("R1 cfg", d, 8'h00);
    busRead(3'd0, d);    check("R1 preload", d, 8'h00);
    check("R1 ctOutN", ctOutN, 1'b1);
    check("R1 ready", ready, 1'b0);
    check("R1 irq", irq, 1'b0);
  endtask

  task automatic testRegs();
    logic [7:0] d;
    busWrite(3'd0, 8'h12); busWrite(3'd1, 8'h34);
    busRead(3'd0, d); check("R2 preHi", d, 8'h12);
    busRead(3'd1, d); check("R2 preLo", d, 8'h34);
    busWrite(3'd2, 8'h14);
    busRead(3'd2, d); check("R2 cfg", d, 8'h14);
    busWrite(3'd2, 8'h00);
  endtask

  task automatic testCounter();
    logic [15:0] c; logic [7:0] d;
    busWrite(3'd0, 8'h00); busWrite(3'd1, 8'h05);
    busWrite(3'd2, 8'h10);                  // counter, main, irq enabled
    cmd(3'd6);
    readCount(c); check("R3 start load", c, 16'h0005);
    ticks(0, 2);
    readCount(c); check("R3 decrement", c, 16'h0003);
    ticks(1, 2); ticks(2, 1); ticks(3, 1);
    readCount(c); check("R4 unselected ticks", c, 16'h0003);
    busWrite(3'd1, 8'h20);                  // new preload mid-run
    readCount(c); check("R6 run untouched", c, 16'h0003);
    ticks(0, 2);
    check("R5 not yet", ready, 1'b0);
    ticks(0, 1);
    readCount(c); check("R5 zero", c, 16'h0000);
    check("R5 ready", ready, 1'b1);
    check("R5 ctOutN", ctOutN, 1'b0);
    check("R12 irq on", irq, 1'b1);
    busRead(3'd5, d); check("R2 status", d, 8'h01);
    ticks(0, 1);
    readCount(c); check("R5 wrap", c, 16'hFFFF);
    check("R5 ready kept", ready, 1'b1);
    busWrite(3'd2, 8'h00);
    check("R12 irq masked", irq, 1'b0);
    cmd(3'd7);
    check("R7 ready cleared", ready, 1'b0);
    check("R7 ctOutN", ctOutN, 1'b1);
    ticks(0, 3);
    readCount(c); check("R7 halted", c, 16'hFFFF);
    cmd(3'd6);
    readCount(c); check("R6 new preload", c, 16'h0020);
    busWrite(3'd2, 8'h04);                  // chanB source
    ticks(0, 2); ticks(2, 3);
    readCount(c); check("R4 chanB", c, 16'h001D);
    cmd(3'd7);
  endtask

  task automatic testTimer();
    logic [15:0] c;
    busWrite(3'd0, 8'h00); busWrite(3'd1, 8'h03);
    busWrite(3'd2, 8'h01);                  // timer, main, div1
    readCount(c); check("R8 entry load", c, 16'h0003);
    check("R8 out clear", ctOutN, 1'b1);
    ticks(0, 2);
    check("R9 no toggle yet", ctOutN, 1'b1);
    ticks(0, 1);
    check("R9 toggle 1", ctOutN, 1'b0);
    check("R9 ready", ready, 1'b1);
    readCount(c); check("R9 reload", c, 16'h0003);
    ticks(0, 2);
    check("R9 half hold", ctOutN, 1'b0);
    ticks(0, 1);
    check("R9 toggle 2", ctOutN, 1'b1);
    cmd(3'd7);
    check("R10 stop clears ready", ready, 1'b0);
    ticks(0, 1);
    readCount(c); check("R10 keeps running", c, 16'h0002);
    cmd(3'd6);
    readCount(c); check("R10 start reload", c, 16'h0003);
    // divide by 16
    busWrite(3'd1, 8'h02);
    busWrite(3'd2, 8'h09);
    cmd(3'd6);
    ticks(0, 15);
    readCount(c); check("R11 div16 hold", c, 16'h0002);
    ticks(0, 1);
    readCount(c); check("R11 div16 step", c, 16'h0001);
    ticks(0, 15);
    check("R11 div16 no toggle", ctOutN, 1'b1);
    ticks(0, 1);
    check("R11 div16 toggle", ctOutN, 1'b0);
    // external source
    busWrite(3'd2, 8'h07);
    cmd(3'd6);
    ticks(0, 2); ticks(1, 1);
    readCount(c); check("R11 ext ignores main", c, 16'h0002);
    ticks(3, 1);
    readCount(c); check("R11 ext step", c, 16'h0001);
    // back to counter mode
    busWrite(3'd2, 8'h00);
    check("R8 exit out clear", ctOutN, 1'b1);
    check("R8 exit ready clear", ready, 1'b0);
    ticks(0, 2);
    readCount(c); check("R8 counter stopped", c, 16'h0002);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testRegs();
    testCounter();
    testTimer();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule